// File: doc/BRIEF.md
# Line-Addressed Field Memory with Twin Scan Readers

This block stores an image as a grid of lines, each holding a fixed number of 12-bit pixels. It has one writer and two readers, and each of the three has its own scan cursor. A client starts an access by loading a line number and a pixel offset within that line. After that the cursor walks through the image one pixel per enabled clock. At the end of a line it moves to the first pixel of the next line, and after the last line it returns to line 0. The two readers are independent, so they can scan different lines in the same cycle. One example is a filter that needs the current line and the line above it.

Writes can protect parts of the stored pixel. In plain mode every pixel bit has its own protect bit. In luma/chroma mode the pixel is split into an upper 8-bit luma field and a lower 4-bit chroma field, and one protect bit covers each field. This lets a single pass update brightness or colour alone. The line length and the line count are parameters.

Top module: `line_field_mem`

## Requirements
- R1: After reset both read data outputs are 0, and all three cursors sit at line 0, pixel 0. The first plain write after reset lands at line 0, pixel 0, and the first plain read step returns that pixel.
- R2: When wr_en_i is high and wr_load_i is low, wr_data_i is stored at the write cursor and the cursor advances by one pixel. When wr_load_i is high, the cursor takes the loaded position and nothing is stored in that cycle.
- R3: A read load (rd_load_i[p] high) puts the pixel at the loaded line/pixel on rd_data_o for port p one clock later. The cursor then points at the pixel that follows it.
- R4: With rd_en_i[p] high and no load, port p outputs the cursor's pixel one clock later and advances. With neither load nor enable, the output and the cursor hold.
- R5: Advancing from the last pixel of a line goes to pixel 0 of the next line. Advancing from the last pixel of the last line goes to line 0, pixel 0. This holds for the writer and for both readers.
- R6: A load strobe wins over an enable in the same cycle. The write port stores nothing in that cycle. A read port shows the loaded pixel, not the next sequential one.
- R7: The two read ports keep separate cursors and outputs. A load or enable on one port leaves the other port's output and position unchanged.
- R8: With yc_mode_i low, wr_mask_i[i]=1 keeps stored bit i, and wr_mask_i[i]=0 lets bit i take wr_data_i[i].
- R9: With yc_mode_i high, wr_mask_i[1]=1 keeps bits 11:4 (luma) and wr_mask_i[0]=1 keeps bits 3:0 (chroma). wr_mask_i[11:2] is ignored.
- R10: On any load, a line number of LINES or more is taken as line 0, and a pixel offset of WORDS or more is taken as pixel 0. Each coordinate is checked on its own.
- R11: A read that targets the pixel being written in the same cycle returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| yc_mode_i | input | 1 | 1: luma/chroma field masking, 0: per-bit masking |
| wr_load_i | input | 1 | Load the write cursor from wr_line_i/wr_word_i |
| wr_line_i | input | LW | Write start line |
| wr_word_i | input | WW | Write start pixel within the line |
| wr_en_i | input | 1 | Store one pixel and advance |
| wr_data_i | input | PIX_W | Pixel to store |
| wr_mask_i | input | PIX_W | Protect bits (per bit, or [1]=luma and [0]=chroma) |
| rd_load_i | input | NRD | Per read port: load the cursor and fetch |
| rd_line_i | input | NRD*LW | Per read port start line, port p at [p*LW +: LW] |
| rd_word_i | input | NRD*WW | Per read port start pixel, port p at [p*WW +: WW] |
| rd_en_i | input | NRD | Per read port: fetch the next pixel |
| rd_data_o | output | NRD*PIX_W | Registered read pixel, port p at [p*PIX_W +: PIX_W] |

## Verification
A bad cursor state does not stay hidden. The next read step or load on that port returns a pixel from the wrong place, one clock later, and a bad write cursor damages a pixel that a later read sweep exposes. The reference model tracks every cursor and every stored pixel. It compares both read outputs on every clock, so a wrong wrap, a wrong clamp or a wrong priority shows within one cycle of the read that reveals it. Mask faults appear on the first read-back of the pixel that was written.

// File: rtl/line_field_pkg.sv
package line_field_pkg;
  // protect-bit positions used in luma/chroma mode
  localparam int unsigned YC_LUMA_MBIT   = 1;
  localparam int unsigned YC_CHROMA_MBIT = 0;

  // what a load does with the cursor
  typedef enum logic {
    LOAD_PARKS   = 1'b0,  // load only positions the cursor
    LOAD_FETCHES = 1'b1   // load accesses the loaded pixel and steps past it
  } load_mode_e;
endpackage

// File: rtl/scan_cursor.sv
module scan_cursor
  import line_field_pkg::*;
#(
  parameter int unsigned WORDS = 12,
  parameter int unsigned LINES = 5,
  parameter load_mode_e  MODE  = LOAD_PARKS,
  localparam int unsigned LW = $clog2(LINES),
  localparam int unsigned WW = $clog2(WORDS),
  localparam int unsigned IW = $clog2(WORDS * LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [LW-1:0] line_i,
  input  logic [WW-1:0] word_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);
  localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);

  logic [LW-1:0] line_q, line_d, ld_line, sel_line, adv_line_in, adv_line;
  logic [WW-1:0] word_q, word_d, ld_word, sel_word, adv_word_in, adv_word;

  // out-of-range coordinates collapse to 0
  assign ld_line = (line_i <= LAST_LINE) ? line_i : '0;
  assign ld_word = (word_i <= LAST_WORD) ? word_i : '0;

  assign sel_line = load_i ? ld_line : line_q;
  assign sel_word = load_i ? ld_word : word_q;

  generate
    if (MODE == LOAD_FETCHES) begin : g_fetch
      assign hit_o       = load_i | step_i;
      assign adv_line_in = sel_line;
      assign adv_word_in = sel_word;
    end else begin : g_park
      assign hit_o       = step_i & ~load_i;
      assign adv_line_in = line_q;
      assign adv_word_in = word_q;
    end
  endgenerate

  always_comb begin
    adv_line = adv_line_in;
    adv_word = adv_word_in + WW'(1);
    if (adv_word_in == LAST_WORD) begin
      adv_word = '0;
      adv_line = (adv_line_in == LAST_LINE) ? '0 : adv_line_in + LW'(1);
    end
  end

  always_comb begin
    line_d = line_q;
    word_d = word_q;
    if (hit_o) begin
      line_d = adv_line;
      word_d = adv_word;
    end else if (load_i) begin
      line_d = ld_line;
      word_d = ld_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      word_q <= '0;
    end else begin
      line_q <= line_d;
      word_q <= word_d;
    end
  end

  assign idx_o = IW'(sel_line) * IW'(WORDS) + IW'(sel_word);

  p_in_bounds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q <= LAST_LINE) && (word_q <= LAST_WORD));

  p_frame_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && line_q == LAST_LINE && word_q == LAST_WORD)
    |=> (line_q == '0 && word_q == '0));

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(line_q) && $stable(word_q)));
endmodule

// File: rtl/field_array.sv
module field_array #(
  parameter int unsigned DEPTH = 60,
  parameter int unsigned PIX_W = 12,
  parameter int unsigned NRD   = 2,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IW-1:0]        widx_i,
  input  logic [PIX_W-1:0]     wdata_i,
  input  logic [PIX_W-1:0]     keep_i,
  input  logic [NRD-1:0]       ren_i,
  input  logic [NRD*IW-1:0]    ridx_i,
  output logic [NRD*PIX_W-1:0] rdata_o
);
  logic [PIX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= (mem_q[widx_i] & keep_i) | (wdata_i & ~keep_i);
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [PIX_W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          data_q <= '0;
      else if (ren_i[p])    data_q <= mem_q[ridx_i[p*IW +: IW]];
    end

    assign rdata_o[p*PIX_W +: PIX_W] = data_q;

    p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ren_i[p] |=> $stable(rdata_o[p*PIX_W +: PIX_W]));
  end
endmodule

// File: rtl/line_field_mem.sv
module line_field_mem
  import line_field_pkg::*;
#(
  parameter int unsigned WORDS  = 12,
  parameter int unsigned LINES  = 5,
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned LUMA_W = 8,
  parameter int unsigned NRD    = 2,
  localparam int unsigned LW = $clog2(LINES),
  localparam int unsigned WW = $clog2(WORDS),
  localparam int unsigned IW = $clog2(WORDS * LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 yc_mode_i,
  input  logic                 wr_load_i,
  input  logic [LW-1:0]        wr_line_i,
  input  logic [WW-1:0]        wr_word_i,
  input  logic                 wr_en_i,
  input  logic [PIX_W-1:0]     wr_data_i,
  input  logic [PIX_W-1:0]     wr_mask_i,
  input  logic [NRD-1:0]       rd_load_i,
  input  logic [NRD*LW-1:0]    rd_line_i,
  input  logic [NRD*WW-1:0]    rd_word_i,
  input  logic [NRD-1:0]       rd_en_i,
  output logic [NRD*PIX_W-1:0] rd_data_o
);
  localparam int unsigned CHROMA_W = PIX_W - LUMA_W;
  localparam int unsigned DEPTH    = WORDS * LINES;

  logic              wr_hit;
  logic [IW-1:0]     wr_idx;
  logic [PIX_W-1:0]  keep;
  logic [NRD-1:0]    rd_hit;
  logic [NRD*IW-1:0] rd_idx;

  assign keep = yc_mode_i
    ? {{LUMA_W{wr_mask_i[YC_LUMA_MBIT]}}, {CHROMA_W{wr_mask_i[YC_CHROMA_MBIT]}}}
    : wr_mask_i;

  scan_cursor #(.WORDS(WORDS), .LINES(LINES), .MODE(LOAD_PARKS)) u_wr_cur (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_load_i),
    .step_i (wr_en_i),
    .line_i (wr_line_i),
    .word_i (wr_word_i),
    .hit_o  (wr_hit),
    .idx_o  (wr_idx)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd_cur
    scan_cursor #(.WORDS(WORDS), .LINES(LINES), .MODE(LOAD_FETCHES)) u_rd_cur (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (rd_load_i[p]),
      .step_i (rd_en_i[p]),
      .line_i (rd_line_i[p*LW +: LW]),
      .word_i (rd_word_i[p*WW +: WW]),
      .hit_o  (rd_hit[p]),
      .idx_o  (rd_idx[p*IW +: IW])
    );
  end

  field_array #(.DEPTH(DEPTH), .PIX_W(PIX_W), .NRD(NRD)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_hit),
    .widx_i  (wr_idx),
    .wdata_i (wr_data_i),
    .keep_i  (keep),
    .ren_i   (rd_hit),
    .ridx_i  (rd_idx),
    .rdata_o (rd_data_o)
  );

  // a load on the write port must suppress the store
  p_load_blocks_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_load_i |-> !wr_hit);
endmodule

// File: tb/line_field_mem_tb.sv
module line_field_mem_tb_top;
  localparam int WORDS = 12;
  localparam int LINES = 5;
  localparam int LW = $clog2(LINES);
  localparam int WW = $clog2(WORDS);
  localparam int NRD = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic yc_mode_i = 1'b0;
  logic wr_load_i = 1'b0, wr_en_i = 1'b0;
  logic [LW-1:0] wr_line_i = '0;
  logic [WW-1:0] wr_word_i = '0;
  logic [11:0] wr_data_i = '0, wr_mask_i = '0;
  logic [NRD-1:0] rd_load_i = '0, rd_en_i = '0;
  logic [NRD*LW-1:0] rd_line_i = '0;
  logic [NRD*WW-1:0] rd_word_i = '0;
  logic [NRD*12-1:0] rd_data_o;

  always #5 clk = ~clk;

  line_field_mem dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .yc_mode_i(yc_mode_i),
    .wr_load_i(wr_load_i), .wr_line_i(wr_line_i), .wr_word_i(wr_word_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .wr_mask_i(wr_mask_i),
    .rd_load_i(rd_load_i), .rd_line_i(rd_line_i), .rd_word_i(rd_word_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o)
  );

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference state
  int m_mem [WORDS*LINES];
  int m_wl = 0, m_ww = 0;
  int m_rl [NRD];
  int m_rw [NRD];
  int m_exp [NRD];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic adv(inout int l, inout int w);
    if (w == WORDS - 1) begin
      w = 0;
      l = (l == LINES - 1) ? 0 : l + 1;
    end else w++;
  endtask

  task automatic model_update();
    int l, w, keep;
    for (int p = 0; p < NRD; p++) begin
      if (rd_load_i[p]) begin
        l = int'(rd_line_i[p*LW +: LW]); if (l >= LINES) l = 0;
        w = int'(rd_word_i[p*WW +: WW]); if (w >= WORDS) w = 0;
        m_exp[p] = m_mem[l*WORDS + w];
        adv(l, w);
        m_rl[p] = l; m_rw[p] = w;
      end else if (rd_en_i[p]) begin
        m_exp[p] = m_mem[m_rl[p]*WORDS + m_rw[p]];
        l = m_rl[p]; w = m_rw[p];
        adv(l, w);
        m_rl[p] = l; m_rw[p] = w;
      end
    end
    if (wr_load_i) begin
      m_wl = int'(wr_line_i); if (m_wl >= LINES) m_wl = 0;
      m_ww = int'(wr_word_i); if (m_ww >= WORDS) m_ww = 0;
    end else if (wr_en_i) begin
      if (yc_mode_i) keep = (wr_mask_i[1] ? 12'hFF0 : 0) | (wr_mask_i[0] ? 12'h00F : 0);
      else keep = int'(wr_mask_i);
      m_mem[m_wl*WORDS + m_ww] = (m_mem[m_wl*WORDS + m_ww] & keep) | (int'(wr_data_i) & ~keep & 12'hFFF);
      adv(m_wl, m_ww);
    end
  endtask

  task automatic tick();
    if (rst_ni) model_update();
    @(negedge clk);
    for (int p = 0; p < NRD; p++)
      chk(cur_req, int'(rd_data_o[p*12 +: 12]), m_exp[p]);
  endtask

  task automatic rd_ld(input int p, input int l, input int w);
    rd_load_i[p] = 1'b1;
    rd_line_i[p*LW +: LW] = LW'(l);
    rd_word_i[p*WW +: WW] = WW'(w);
  endtask

  task automatic quiet();
    rd_load_i = '0; rd_en_i = '0; wr_load_i = 0; wr_en_i = 0; wr_mask_i = '0;
  endtask

  initial begin
    for (int i = 0; i < WORDS*LINES; i++) m_mem[i] = 0;
    for (int p = 0; p < NRD; p++) begin m_rl[p] = 0; m_rw[p] = 0; m_exp[p] = 0; end
    // R1: reset state
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
    // R2 / R1: sequential fill from the reset cursor
    cur_req = "R2";
    wr_en_i = 1;
    for (int i = 0; i < WORDS*LINES; i++) begin wr_data_i = 12'(i*37 + 5); tick(); end
    // R5: write cursor wraps to line 0
    cur_req = "R5";
    for (int i = 0; i < 3; i++) begin wr_data_i = 12'(12'hA00 + i); tick(); end
    quiet();
    // R1: first read step after reset returns line 0 pixel 0
    cur_req = "R1";
    rd_en_i[0] = 1; tick(); quiet();
    chk("R1", int'(rd_data_o[11:0]), 'hA00);
    // R3: loads on both ports
    cur_req = "R3";
    rd_ld(0, 1, 10); rd_ld(1, 3, 0); tick(); quiet();
    chk("R3", int'(rd_data_o[11:0]), (22*37 + 5) & 'hFFF);
    // R4: streaming, then idle hold
    cur_req = "R4";
    rd_en_i = 2'b11; repeat (6) tick(); quiet(); repeat (2) tick();
    // R5: read wrap from the last pixel of the last line
    cur_req = "R5";
    rd_ld(1, 4, 11); tick(); quiet(); rd_en_i[1] = 1; repeat (2) tick(); quiet();
    // R7: ports independent
    cur_req = "R7";
    rd_en_i[0] = 1; rd_ld(1, 2, 5); tick(); rd_load_i = '0; rd_en_i[0] = 1; repeat (2) tick(); quiet();
    // R6: load wins over enable
    cur_req = "R6";
    rd_ld(0, 0, 4); rd_en_i[0] = 1; tick(); quiet();
    wr_load_i = 1; wr_line_i = 2; wr_word_i = 0; wr_en_i = 1; wr_data_i = 12'hFFF; tick(); quiet();
    wr_en_i = 1; wr_data_i = 12'h123; tick(); quiet();
    rd_ld(0, 2, 0); tick(); quiet();
    chk("R6", int'(rd_data_o[11:0]), 'h123);
    // R8: per-bit masking
    cur_req = "R8";
    yc_mode_i = 0; wr_load_i = 1; wr_line_i = 1; wr_word_i = 0; tick(); quiet();
    wr_en_i = 1;
    wr_data_i = 12'hABC; wr_mask_i = 12'h0F0; tick();
    wr_data_i = 12'h555; wr_mask_i = 12'hF0F; tick();
    wr_data_i = 12'hFFF; wr_mask_i = 12'hFFF; tick();
    wr_data_i = 12'h000; wr_mask_i = 12'h000; tick();
    quiet(); rd_ld(1, 1, 0); tick(); quiet(); rd_en_i[1] = 1; repeat (3) tick(); quiet();
    // R9: luma/chroma masking, high mask bits ignored
    cur_req = "R9";
    yc_mode_i = 1; wr_load_i = 1; wr_line_i = 1; wr_word_i = 0; tick(); quiet();
    wr_en_i = 1;
    wr_data_i = 12'h9A7; wr_mask_i = 12'h002; tick();
    wr_data_i = 12'h3C1; wr_mask_i = 12'h001; tick();
    wr_data_i = 12'h6E2; wr_mask_i = 12'hFFC; tick();
    wr_data_i = 12'h111; wr_mask_i = 12'h003; tick();
    quiet(); rd_ld(0, 1, 0); tick(); quiet(); rd_en_i[0] = 1; repeat (3) tick(); quiet();
    chk("R9", int'(rd_data_o[11:0]), m_mem[WORDS + 3]);
    yc_mode_i = 0;
    // R10: out-of-range coordinates
    cur_req = "R10";
    rd_ld(0, 6, 3); rd_ld(1, 2, 14); tick(); quiet();
    rd_ld(0, 7, 15); tick(); quiet();
    wr_load_i = 1; wr_line_i = 7; wr_word_i = 12; tick(); quiet();
    wr_en_i = 1; wr_data_i = 12'h7E7; tick(); quiet();
    rd_ld(1, 0, 0); tick(); quiet();
    chk("R10", int'(rd_data_o[23:12]), 'h7E7);
    // R11: read during write of the same pixel sees the old value
    cur_req = "R11";
    wr_load_i = 1; wr_line_i = 3; wr_word_i = 3; tick(); quiet();
    wr_en_i = 1; wr_data_i = 12'hC0D; rd_ld(0, 3, 3); tick(); quiet();
    chk("R11", int'(rd_data_o[11:0]) == 'hC0D ? 1 : 0, 0);
    rd_ld(0, 3, 3); tick(); quiet();
    chk("R11", int'(rd_data_o[11:0]), 'hC0D);
    // R7: mixed random traffic on all ports
    cur_req = "R7";
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NRD; p++) begin
        rd_load_i[p] = ($urandom_range(7) == 0);
        rd_en_i[p] = $urandom_range(1);
        rd_line_i[p*LW +: LW] = LW'($urandom_range(7));
        rd_word_i[p*WW +: WW] = WW'($urandom_range(15));
      end
      wr_load_i = ($urandom_range(9) == 0);
      wr_en_i = $urandom_range(1);
      wr_line_i = LW'($urandom_range(7));
      wr_word_i = WW'($urandom_range(15));
      wr_data_i = 12'($urandom);
      wr_mask_i = ($urandom_range(3) == 0) ? 12'($urandom) : 12'h000;
      yc_mode_i = $urandom_range(1);
      tick();
    end
    quiet();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL %s: watchdog expired actual=hung expected=finished", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule